// File: doc/BRIEF.md
# DRAM Frequency-Change Sequencer

This block runs the hardware side of a memory clock frequency change. Software stages new refresh timing and a new on-die-termination map in shadow registers, then sets a start bit in the control register. The sequencer waits until every bus master either reports ready or has been excused by a mask bit. It then optionally freezes the I/O pads, asks an external clock switcher to change the clock and waits for its acknowledge. Finally it fires an active-low apply strobe for one cycle, in which the staged timing is copied to the live registers. The start bit then clears by itself, so software detects completion by polling it.

When double buffering is off, timing writes reach the live registers at once. Writing zero to the control register after a change turns buffering off again. The control register cannot be changed while a change is in flight. The live refresh register is also decoded into its interval and cycle-time fields for the controller core.

Top module: `freq_switch_seq`

## Requirements
- R1: After reset the control register reads 0, both live registers read 0, `apply_n_o` is 1, and `clk_sw_req_o` and `pad_hold_o` are 0.
- R2: The control register (index 0) holds start in bit 0, mode in bit 1, bypass in bit 4, pad-hold enable in bit 13 and buffer enable in bit 15. All other bits read 0. Mode and bypass are driven on `sw_mode_o` and `sw_bypass_o`.
- R3: With buffer enable clear, a write to the refresh register (index 2) or the ODT register (index 3) updates the shadow and the live copy on the same clock edge. Writing 0 to the control register clears buffer enable.
- R4: With buffer enable set, a timing write updates only the shadow, which reads back at its index. The live copy is unchanged until the apply strobe.
- R5: Writing control with bit 0 set while idle makes bit 0 read 1 from the next cycle until the sequence ends, after which hardware clears it. Control writes made during a sequence are ignored.
- R6: The sequence does not proceed until every master i has `master_rdy_i[i]` high or mask bit i set. The mask register is at index 1.
- R7: When pad-hold enable is set, `pad_hold_o` is high for one hold cycle, every clock-request cycle and the apply cycle. It is low throughout when pad-hold enable is clear.
- R8: `clk_sw_req_o` stays high until `clk_sw_ack_i` is seen. The apply strobe does not occur before that.
- R9: Each sequence drives `apply_n_o` low for exactly one cycle. At the end of that cycle the live registers take the shadow values.
- R10: `refi_o` equals bits 31:16 of the live refresh register (interval in units of 32 clocks). `trfc_o` equals bits 15:0 (cycle time in clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W | Register index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| master_rdy_i | input | N_MASTERS | Per-master ready for a frequency change |
| clk_sw_req_o | output | 1 | Request to the clock switcher |
| clk_sw_ack_i | input | 1 | Acknowledge from the clock switcher |
| sw_mode_o | output | 1 | Switch mode: 0 divider change, 1 clock-source change |
| sw_bypass_o | output | 1 | Bypass setting for the clock switcher |
| pad_hold_o | output | 1 | Freeze memory I/O pads |
| apply_n_o | output | 1 | Active-low apply strobe |
| live_rfsh_o | output | 32 | Live refresh timing |
| live_odt_o | output | 32 | Live ODT map |
| refi_o | output | 16 | Live refresh interval field |
| trfc_o | output | 16 | Live refresh cycle-time field |

## Verification
The assertions assume that the clock switcher raises its acknowledge only while the request is high and drops it once the request falls. They also assume that software does not clear buffering and write timing registers during a sequence. The bench keeps to both. Its acknowledge follows the request after a chosen delay. All timing writes during a sequence are made with buffering enabled, so any change to the live registers outside the strobe cycle comes from a direct write.

// File: rtl/freq_switch_pkg.sv
package freq_switch_pkg;
  localparam int REG_W = 32;

  localparam int IDX_CTRL = 0;
  localparam int IDX_MASK = 1;
  localparam int IDX_RFSH = 2;
  localparam int IDX_ODT  = 3;

  localparam int CB_START   = 0;
  localparam int CB_MODE    = 1;
  localparam int CB_BYPASS  = 4;
  localparam int CB_PADHOLD = 13;
  localparam int CB_BUFEN   = 15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_READY, ST_HOLD_PADS, ST_SWITCH, ST_COMMIT, ST_DONE
  } seq_state_t;

  function automatic logic [REG_W-1:0] pack_ctrl(input logic busy, input logic mode,
                                                 input logic bypass, input logic padhold,
                                                 input logic bufen);
    logic [REG_W-1:0] v;
    v = '0;
    v[CB_START]   = busy;
    v[CB_MODE]    = mode;
    v[CB_BYPASS]  = bypass;
    v[CB_PADHOLD] = padhold;
    v[CB_BUFEN]   = bufen;
    return v;
  endfunction

  function automatic logic [15:0] refi_of(input logic [REG_W-1:0] r);
    return r[31:16];
  endfunction

  function automatic logic [15:0] trfc_of(input logic [REG_W-1:0] r);
    return r[15:0];
  endfunction
endpackage

// File: rtl/fs_ready_gate.sv
module fs_ready_gate #(
  parameter int N_MASTERS = 8
) (
  input  logic [N_MASTERS-1:0] rdy_i,
  input  logic [N_MASTERS-1:0] mask_i,
  output logic                 all_ready_o
);
  logic [N_MASTERS-1:0] ok;

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_master
    assign ok[g] = rdy_i[g] | mask_i[g];
  end

  assign all_ready_o = &ok;
endmodule

// File: rtl/fs_regs.sv
module fs_regs
  import freq_switch_pkg::*;
#(
  parameter int N_MASTERS = 8,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic                 busy_i,
  input  logic                 commit_i,
  output logic [N_MASTERS-1:0] mask_o,
  output logic                 mode_o,
  output logic                 bypass_o,
  output logic                 padhold_en_o,
  output logic                 start_req_o,
  output logic                 direct_wr_o,
  output logic [REG_W-1:0]     rdata_o,
  output logic [REG_W-1:0]     live_rfsh_o,
  output logic [REG_W-1:0]     live_odt_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IDX_CTRL);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(IDX_MASK);
  localparam logic [ADDR_W-1:0] A_RFSH = ADDR_W'(IDX_RFSH);
  localparam logic [ADDR_W-1:0] A_ODT  = ADDR_W'(IDX_ODT);

  logic                 mode_q, bypass_q, padhold_q, bufen_q;
  logic [N_MASTERS-1:0] mask_q;
  logic [REG_W-1:0]     sh_rfsh_q, sh_odt_q, lv_rfsh_q, lv_odt_q;
  logic                 ctrl_wr, rfsh_wr, odt_wr;

  assign ctrl_wr     = wr_i && (addr_i == A_CTRL) && !busy_i;
  assign rfsh_wr     = wr_i && (addr_i == A_RFSH);
  assign odt_wr      = wr_i && (addr_i == A_ODT);
  assign start_req_o = ctrl_wr && wdata_i[CB_START];
  assign direct_wr_o = !bufen_q && (rfsh_wr || odt_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      bypass_q  <= 1'b0;
      padhold_q <= 1'b0;
      bufen_q   <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q    <= wdata_i[CB_MODE];
      bypass_q  <= wdata_i[CB_BYPASS];
      padhold_q <= wdata_i[CB_PADHOLD];
      bufen_q   <= wdata_i[CB_BUFEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_i && addr_i == A_MASK) mask_q <= wdata_i[N_MASTERS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_rfsh_q <= '0;
      sh_odt_q  <= '0;
    end else begin
      if (rfsh_wr) sh_rfsh_q <= wdata_i;
      if (odt_wr)  sh_odt_q  <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_rfsh_q <= '0;
      lv_odt_q  <= '0;
    end else begin
      if (commit_i) begin
        lv_rfsh_q <= sh_rfsh_q;
        lv_odt_q  <= sh_odt_q;
      end
      if (!bufen_q && rfsh_wr) lv_rfsh_q <= wdata_i;
      if (!bufen_q && odt_wr)  lv_odt_q  <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = pack_ctrl(busy_i, mode_q, bypass_q, padhold_q, bufen_q);
      A_MASK:  rdata_o = REG_W'(mask_q);
      A_RFSH:  rdata_o = sh_rfsh_q;
      A_ODT:   rdata_o = sh_odt_q;
      default: rdata_o = '0;
    endcase
  end

  assign mask_o       = mask_q;
  assign mode_o       = mode_q;
  assign bypass_o     = bypass_q;
  assign padhold_en_o = padhold_q;
  assign live_rfsh_o  = lv_rfsh_q;
  assign live_odt_o   = lv_odt_q;
endmodule

// File: rtl/fs_ctrl_fsm.sv
module fs_ctrl_fsm
  import freq_switch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req_i,
  input  logic all_ready_i,
  input  logic padhold_en_i,
  input  logic ack_i,
  output logic busy_o,
  output logic in_wait_o,
  output logic req_o,
  output logic pad_hold_o,
  output logic commit_o
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (start_req_i) state_d = ST_WAIT_READY;
      ST_WAIT_READY: if (all_ready_i) state_d = padhold_en_i ? ST_HOLD_PADS : ST_SWITCH;
      ST_HOLD_PADS:  state_d = ST_SWITCH;
      ST_SWITCH:     if (ack_i) state_d = ST_COMMIT;
      ST_COMMIT:     state_d = ST_DONE;
      ST_DONE:       state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign in_wait_o  = (state_q == ST_WAIT_READY);
  assign req_o      = (state_q == ST_SWITCH);
  assign commit_o   = (state_q == ST_COMMIT);
  assign pad_hold_o = padhold_en_i && ((state_q == ST_HOLD_PADS) ||
                                       (state_q == ST_SWITCH) ||
                                       (state_q == ST_COMMIT));
endmodule

// File: rtl/freq_switch_seq.sv
module freq_switch_seq
  import freq_switch_pkg::*;
#(
  parameter int N_MASTERS = 8,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [N_MASTERS-1:0] master_rdy_i,
  output logic                 clk_sw_req_o,
  input  logic                 clk_sw_ack_i,
  output logic                 sw_mode_o,
  output logic                 sw_bypass_o,
  output logic                 pad_hold_o,
  output logic                 apply_n_o,
  output logic [31:0]          live_rfsh_o,
  output logic [31:0]          live_odt_o,
  output logic [15:0]          refi_o,
  output logic [15:0]          trfc_o
);
  logic [N_MASTERS-1:0] mask_w;
  logic busy_w, in_wait_w, commit_w, start_req_w, direct_wr_w, all_ready_w, padhold_en_w;
  logic wait_blocked_w;

  fs_regs #(.N_MASTERS(N_MASTERS), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy_w), .commit_i(commit_w), .mask_o(mask_w), .mode_o(sw_mode_o),
    .bypass_o(sw_bypass_o), .padhold_en_o(padhold_en_w), .start_req_o(start_req_w),
    .direct_wr_o(direct_wr_w), .rdata_o(reg_rdata_o), .live_rfsh_o(live_rfsh_o),
    .live_odt_o(live_odt_o)
  );

  fs_ready_gate #(.N_MASTERS(N_MASTERS)) gate_i (
    .rdy_i(master_rdy_i), .mask_i(mask_w), .all_ready_o(all_ready_w)
  );

  fs_ctrl_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .start_req_i(start_req_w), .all_ready_i(all_ready_w),
    .padhold_en_i(padhold_en_w), .ack_i(clk_sw_ack_i), .busy_o(busy_w),
    .in_wait_o(in_wait_w), .req_o(clk_sw_req_o), .pad_hold_o(pad_hold_o),
    .commit_o(commit_w)
  );

  assign apply_n_o      = !commit_w;
  assign wait_blocked_w = in_wait_w && !all_ready_w;
  assign refi_o         = refi_of(live_rfsh_o);
  assign trfc_o         = trfc_of(live_rfsh_o);
endmodule

// File: rtl/freq_switch_seq_chk.sv
module freq_switch_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        apply_n,
  input logic        req,
  input logic        ack,
  input logic        busy,
  input logic        pad_hold,
  input logic        direct_wr,
  input logic        in_wait,
  input logic        wait_blocked,
  input logic [31:0] live_rfsh,
  input logic [31:0] live_odt
);
  assert_apply_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_n |=> apply_n);

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req);

  assert_live_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    apply_n && !direct_wr |=> $stable(live_rfsh) && $stable(live_odt));

  assert_wait_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_blocked |=> in_wait);

  assert_pad_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pad_hold |-> busy);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> apply_n && !req);
endmodule

bind freq_switch_seq freq_switch_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .apply_n(apply_n_o), .req(clk_sw_req_o), .ack(clk_sw_ack_i),
  .busy(busy_w), .pad_hold(pad_hold_o), .direct_wr(direct_wr_w), .in_wait(in_wait_w),
  .wait_blocked(wait_blocked_w), .live_rfsh(live_rfsh_o), .live_odt(live_odt_o)
);

// File: tb/freq_switch_seq_tb.sv
module freq_switch_seq_tb_top;
  localparam int NM = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NM-1:0] rdy = '1;
  logic        req, ack = 1'b0, mode, bypass, pad, apply_n;
  logic [31:0] live_rfsh, live_odt;
  logic [15:0] refi, trfc;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  freq_switch_seq #(.N_MASTERS(NM), .ADDR_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .master_rdy_i(rdy),
    .clk_sw_req_o(req), .clk_sw_ack_i(ack), .sw_mode_o(mode), .sw_bypass_o(bypass),
    .pad_hold_o(pad), .apply_n_o(apply_n), .live_rfsh_o(live_rfsh),
    .live_odt_o(live_odt), .refi_o(refi), .trfc_o(trfc)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Run until the start bit clears; acknowledge after ack_delay request cycles.
  task automatic run_seq(input int ack_delay, input logic [31:0] old_rfsh,
                         output int applies, output int pads, output int reqs, output bit froze_ok);
    int reqcnt;
    applies = 0; pads = 0; reqs = 0; reqcnt = 0; froze_ok = 1;
    reg_addr = 2'd0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (!apply_n) applies++;
      if (pad) pads++;
      if (req) begin
        reqs++;
        if (!ack && live_rfsh !== old_rfsh) froze_ok = 0;
        if (reqcnt >= ack_delay) ack = 1'b1;
        reqcnt++;
      end else ack = 1'b0;
      if (reg_rdata[0] == 1'b0) break;
    end
    ack = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d);
    check(d == 32'h0, "R1 ctrl", d, 32'h0);
    check(live_rfsh == 0 && live_odt == 0, "R1 live", live_rfsh, 32'h0);
    check(apply_n == 1'b1 && req == 1'b0 && pad == 1'b0, "R1 strobes",
          {29'd0, apply_n, req, pad}, 32'h4);
  endtask

  task automatic t_direct;
    wr(2'd2, 32'h0123_0045);
    wr(2'd3, 32'h0000_00A5);
    #1;
    check(live_rfsh == 32'h0123_0045, "R3 live rfsh", live_rfsh, 32'h0123_0045);
    check(live_odt == 32'h0000_00A5, "R3 live odt", live_odt, 32'h0000_00A5);
    check(refi == 16'h0123, "R10 refi", {16'd0, refi}, 32'h0123);
    check(trfc == 16'h0045, "R10 trfc", {16'd0, trfc}, 32'h0045);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    wr(2'd0, 32'h0000_A012);
    rd(2'd0, d);
    check(d == 32'h0000_A012, "R2 ctrl fields", d, 32'h0000_A012);
    check(mode && bypass, "R2 mode/bypass pins", {30'd0, mode, bypass}, 32'h3);
    wr(2'd0, 32'hFFFF_5FEC);
    rd(2'd0, d);
    check(d == 32'h0, "R2 unused bits", d, 32'h0);
  endtask

  task automatic t_buffered;
    logic [31:0] d;
    wr(2'd0, 32'h0000_8000);
    wr(2'd2, 32'h0200_0030);
    wr(2'd3, 32'h0000_0011);
    #1;
    check(live_rfsh == 32'h0123_0045, "R4 live rfsh held", live_rfsh, 32'h0123_0045);
    check(live_odt == 32'h0000_00A5, "R4 live odt held", live_odt, 32'h0000_00A5);
    rd(2'd2, d);
    check(d == 32'h0200_0030, "R4 shadow readback", d, 32'h0200_0030);
  endtask

  task automatic t_run_plain;
    logic [31:0] d;
    int ap, pd, rq; bit fz;
    wr(2'd1, 32'h0000_00FF);
    wr(2'd0, 32'h0000_8001);
    rd(2'd0, d);
    check(d[0] == 1'b1, "R5 start reads busy", d, 32'h1);
    run_seq(3, 32'h0123_0045, ap, pd, rq, fz);
    check(ap == 1, "R9 one apply cycle", ap, 1);
    check(pd == 0, "R7 no pad hold", pd, 0);
    check(rq == 4, "R8 request until ack", rq, 4);
    check(fz, "R8 no commit before ack", {31'd0, fz}, 1);
    rd(2'd0, d);
    check(d[0] == 1'b0, "R5 start self-clears", d, 32'h0);
    check(live_rfsh == 32'h0200_0030 && live_odt == 32'h11, "R9 live takes shadow",
          live_rfsh, 32'h0200_0030);
    check(apply_n == 1'b1, "R9 strobe released", {31'd0, apply_n}, 1);
  endtask

  task automatic t_run_pad;
    int ap, pd, rq; bit fz;
    wr(2'd2, 32'h0300_0050);
    wr(2'd0, 32'h0000_A001);
    run_seq(2, 32'h0200_0030, ap, pd, rq, fz);
    check(pd == 2 + 3, "R7 pad hold cycles", pd, 5);
    check(ap == 1, "R9 one apply cycle pad", ap, 1);
    #1;
    check(pad == 1'b0, "R7 pad released", {31'd0, pad}, 0);
    check(refi == 16'h0300 && trfc == 16'h0050, "R10 fields after commit",
          {refi, trfc}, 32'h0300_0050);
  endtask

  task automatic t_ready_mask;
    logic [31:0] d;
    int ap, pd, rq; bit fz;
    bit req_seen;
    wr(2'd1, 32'h0);
    rdy = 8'h7F;
    wr(2'd2, 32'h0400_0060);
    wr(2'd0, 32'h0000_8001);
    req_seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      if (req) req_seen = 1;
    end
    rd(2'd0, d);
    check(d[0] == 1'b1 && !req_seen, "R6 blocked by unready master", d, 32'h8001);
    wr(2'd0, 32'h0000_0002);
    rd(2'd0, d);
    check(d == 32'h0000_8001, "R5 ctrl write ignored while busy", d, 32'h0000_8001);
    wr(2'd1, 32'h0000_0080);
    run_seq(0, 32'h0300_0050, ap, pd, rq, fz);
    rd(2'd0, d);
    check(d[0] == 1'b0 && live_rfsh == 32'h0400_0060, "R6 mask releases sequence",
          live_rfsh, 32'h0400_0060);
    rdy = '1;
  endtask

  task automatic t_unbuffer;
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h0000_0077);
    #1;
    check(live_odt == 32'h77, "R3 zero ctrl ends buffering", live_odt, 32'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_layout();
    t_buffered();
    t_run_plain();
    t_run_pad();
    t_ready_mask();
    t_unbuffer();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule